// File: doc/BRIEF.md
# Global-History Two-Level Direction Predictor

This block guesses whether a conditional branch will be taken. A low slice of the fetch address picks a row of small state machines. The two lowest address bits are skipped because instructions are word aligned. A short register of recent global branch outcomes then picks one state machine within that row. Each state machine holds two bits: the direction it currently predicts, and whether its last guess was wrong. The predicted direction changes only after two wrong guesses in a row.

The fetch side presents an address and receives the predicted direction at once, together with the outcome history the guess was made with. When the branch later resolves in execute, the back end returns the branch address, that captured history and the real outcome. The block then updates the same state machine that made the guess, and shifts the outcome into the global history. Target addresses and rollback of speculative history are handled elsewhere.

Top module: `gh2l_predictor`

## Requirements
- R1: After reset, every state machine predicts not-taken with its wrong mark clear, the history reads zero, and every lookup returns `lu_taken`=0 and `lu_hist`=0.
- R2: The row is chosen only by `lu_pc[IDX_W+1:2]` (and `up_pc[IDX_W+1:2]` for updates). Changing PC bits 1:0, or any bit above IDX_W+1, selects the same state machine.
- R3: Each accepted update (`up_valid`=1) shifts `up_taken` into history bit 0 and discards the oldest bit. Without an update, the history holds its value.
- R4: A lookup uses the state machine at index {current history, PC row}, with the history in the upper bits. It presents the current history on `lu_hist`.
- R5: When the resolved outcome equals the stored direction, the state machine keeps its direction and clears its wrong mark. A later single miss therefore leaves the prediction unchanged.
- R6: A first miss (wrong mark clear) keeps the predicted direction and sets the wrong mark.
- R7: A second miss in a row (wrong mark set) reverses the predicted direction and leaves the wrong mark set. A third miss in a row is therefore seen as agreement with the new direction.
- R8: An update writes the state machine at index {`up_hist`, `up_pc` row}, whatever the current history is.
- R9: A lookup of the state machine that is being updated in the same cycle returns the value from before the update. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lu_pc | input | PC_W | Fetch address to predict |
| lu_taken | output | 1 | Predicted direction, 1 = taken |
| lu_hist | output | HIST_W | History used for this lookup, to be carried with the branch |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_hist | input | HIST_W | History captured at the lookup of that branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The wrong mark cannot be seen at the ports. A corrupted mark shows up only on a later miss: the prediction then flips one miss too early or too late. A wrong history bit is visible on `lu_hist` in the very next cycle. After that it steers lookups to a different state machine. The bench keeps a behavioural model of every state machine and of the history, and compares both outputs on every cycle. Directed miss sequences, address aliasing and a long run of mixed stimulus expose such faults within a few updates.

// File: rtl/gh2l_pkg.sv
package gh2l_pkg;
  // one predictor cell: direction it predicts and whether the last guess missed
  typedef struct packed {
    logic dir;
    logic missed;
  } cell_t;

  localparam cell_t CELL_RESET = '{dir: 1'b0, missed: 1'b0};
endpackage

// File: rtl/gh2l_rst_sync.sv
module gh2l_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/gh2l_history.sv
module gh2l_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q, hist_d, shifted;

  generate
    if (HIST_W == 1) begin : g_one
      assign shifted = shift_bit;
    end else begin : g_many
      assign shifted = {hist_q[HIST_W-2:0], shift_bit};
    end
  endgenerate

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist_o = hist_q;

  // R3
  hist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(shift_bit));

  // R3
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/gh2l_cell_next.sv
module gh2l_cell_next
  import gh2l_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  chk_en,
  input  cell_t cur,
  input  logic  outcome,
  output cell_t nxt
);
  logic miss;

  assign miss = (cur.dir != outcome);

  always_comb begin
    nxt = cur;
    if (!miss) begin
      nxt.missed = 1'b0;
    end else if (!cur.missed) begin
      nxt.missed = 1'b1;
    end else begin
      nxt.dir    = ~cur.dir;
      nxt.missed = 1'b1;
    end
  end

  // R7
  flip_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && (nxt.dir != cur.dir) |-> cur.missed && (nxt.dir == outcome));

  // R5
  hit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && (cur.dir == outcome) |-> !nxt.missed && (nxt.dir == cur.dir));

  // R6
  first_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && !cur.missed && (cur.dir != outcome) |-> nxt.missed && (nxt.dir == cur.dir));
endmodule

// File: rtl/gh2l_cell_table.sv
module gh2l_cell_table
  import gh2l_pkg::*;
#(
  parameter int IDX_TOT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_TOT-1:0] rd_a_idx,
  output cell_t              rd_a,
  input  logic [IDX_TOT-1:0] rd_b_idx,
  output cell_t              rd_b,
  input  logic               wr_en,
  input  logic [IDX_TOT-1:0] wr_idx,
  input  cell_t              wr_cell
);
  localparam int DEPTH = 1 << IDX_TOT;

  cell_t            mem_q [DEPTH];
  logic [DEPTH-1:0] cell_we;

  always_comb begin
    cell_we = '0;
    if (wr_en) cell_we[wr_idx] = 1'b1;
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mem_q[i] <= CELL_RESET;
        else if (cell_we[i]) mem_q[i] <= wr_cell;
      end
    end
  endgenerate

  assign rd_a = mem_q[rd_a_idx];
  assign rd_b = mem_q[rd_b_idx];

  // R9
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_a_idx != $past(wr_idx)) || (rd_a == $past(wr_cell)));

  // R8
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_we));
endmodule

// File: rtl/gh2l_predictor.sv
module gh2l_predictor
  import gh2l_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lu_pc,
  output logic              lu_taken,
  output logic [HIST_W-1:0] lu_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [HIST_W-1:0] up_hist,
  input  logic              up_taken
);
  localparam int IDX_TOT = HIST_W + IDX_W;
  localparam int ROW_LO  = 2;
  localparam int ROW_HI  = ROW_LO + IDX_W - 1;

  logic               srst_n;
  logic [HIST_W-1:0]  hist;
  logic [IDX_TOT-1:0] lu_idx, up_idx;
  cell_t              lu_cell, up_cur, up_nxt;
  logic               unused_pc_bits;

  assign unused_pc_bits = ^{lu_pc[PC_W-1:ROW_HI+1], lu_pc[ROW_LO-1:0],
                            up_pc[PC_W-1:ROW_HI+1], up_pc[ROW_LO-1:0]};

  gh2l_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  gh2l_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst_n     (srst_n),
    .shift_en  (up_valid),
    .shift_bit (up_taken),
    .hist_o    (hist)
  );

  assign lu_idx = {hist,    lu_pc[ROW_HI:ROW_LO]};
  assign up_idx = {up_hist, up_pc[ROW_HI:ROW_LO]};

  gh2l_cell_table #(.IDX_TOT(IDX_TOT)) u_tbl (
    .clk      (clk),
    .rst_n    (srst_n),
    .rd_a_idx (lu_idx),
    .rd_a     (lu_cell),
    .rd_b_idx (up_idx),
    .rd_b     (up_cur),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_cell  (up_nxt)
  );

  gh2l_cell_next u_next (
    .clk     (clk),
    .rst_n   (srst_n),
    .chk_en  (up_valid),
    .cur     (up_cur),
    .outcome (up_taken),
    .nxt     (up_nxt)
  );

  assign lu_taken = lu_cell.dir;
  assign lu_hist  = hist;

  // R1
  lu_known_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !$isunknown({lu_taken, lu_hist}));
endmodule

// File: tb/sim_gh2l_predictor.sv
module sim_gh2l_predictor;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 6;
  localparam int HIST_W = 2;
  localparam int N      = 1 << (IDX_W + HIST_W);
  localparam int HMASK  = (1 << HIST_W) - 1;
  localparam int RMASK  = (1 << IDX_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [PC_W-1:0]   lu_pc, up_pc;
  logic              lu_taken, up_valid, up_taken;
  logic [HIST_W-1:0] lu_hist, up_hist;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // behavioural model
  int m_dir   [N];
  int m_wrong [N];
  int m_hist;

  always #2 clk = ~clk;

  gh2l_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
    .clk, .rst_n, .lu_pc, .lu_taken, .lu_hist,
    .up_valid, .up_pc, .up_hist, .up_taken
  );

  function automatic int cell_of(int h, logic [PC_W-1:0] pc);
    return (h << IDX_W) | (int'(pc >> 2) & RMASK);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive, compare outputs mid-cycle, then advance the model at the edge
  task automatic step(logic [PC_W-1:0] lpc, bit uv, logic [PC_W-1:0] upc,
                      int uh, bit ut, string tag);
    int c;
    lu_pc    = lpc;
    up_valid = uv;
    up_pc    = upc;
    up_hist  = HIST_W'(uh);
    up_taken = ut;
    #1;
    check({tag, " dir"},  int'(lu_taken), m_dir[cell_of(m_hist, lpc)]);
    check({tag, " hist"}, int'(lu_hist),  m_hist);
    @(posedge clk);
    if (uv) begin
      c = cell_of(uh, upc);
      if (m_dir[c] == int'(ut)) begin
        m_wrong[c] = 0;
      end else if (m_wrong[c] == 0) begin
        m_wrong[c] = 1;
      end else begin
        m_dir[c]   = 1 - m_dir[c];
        m_wrong[c] = 1;
      end
      m_hist = ((m_hist << 1) | int'(ut)) & HMASK;
    end
    #1;
  endtask

  // bring the history back to 00 through two not-taken updates of another branch
  task automatic steer_zero(logic [PC_W-1:0] other);
    step(other, 1'b1, other, 3, 1'b0, "R3");
    step(other, 1'b1, other, 3, 1'b0, "R3");
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] a, b;
    a = 32'h0000_0040;
    b = 32'h0000_0104;
    for (int i = 0; i < N; i++) begin
      m_dir[i]   = 0;
      m_wrong[i] = 0;
    end
    m_hist   = 0;
    rst_n    = 1'b0;
    lu_pc    = '0;
    up_pc    = '0;
    up_valid = 1'b0;
    up_hist  = '0;
    up_taken = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1: reset state for a spread of addresses
    for (int i = 0; i < 8; i++) step(32'(i * 52), 1'b0, '0, 0, 1'b0, "R1");

    // R6: first miss keeps not-taken
    step(a, 1'b1, a, 0, 1'b1, "R6");
    steer_zero(b);
    step(a, 1'b0, '0, 0, 1'b0, "R6");
    // R7: second miss flips to taken
    step(a, 1'b1, a, 0, 1'b1, "R7");
    steer_zero(b);
    step(a, 1'b0, '0, 0, 1'b0, "R7");
    // R5: hit clears the mark, so one later miss does not flip
    step(a, 1'b1, a, 0, 1'b1, "R5");
    steer_zero(b);
    step(a, 1'b1, a, 0, 1'b0, "R5");
    steer_zero(b);
    step(a, 1'b0, '0, 0, 1'b0, "R5");
    // R9: second miss while looking up the same cell: old value, then new
    step(a, 1'b1, a, 0, 1'b0, "R9");
    step(a, 1'b0, '0, 0, 1'b0, "R9");
    // R2: aliases of the same row
    step(a | 32'h3,           1'b0, '0, 0, 1'b0, "R2");
    step(a + 32'(1 << (IDX_W + 2)), 1'b0, '0, 0, 1'b0, "R2");
    step(a | 32'hF000_0000,   1'b0, '0, 0, 1'b0, "R2");
    step(a + 4,               1'b0, '0, 0, 1'b0, "R2");
    // R8: write through a history other than the current one
    step(a, 1'b1, a, 2, 1'b1, "R8");
    step(a, 1'b1, a, 2, 1'b1, "R8");
    step(b, 1'b1, b, 1, 1'b1, "R4");
    step(b, 1'b1, b, 1, 1'b0, "R4");
    step(a, 1'b0, '0, 0, 1'b0, "R8");
    // R4: mixed traffic on a small address set so rows collide
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] lp, upc;
      lp  = ($urandom & 32'h0000_003C) | ($urandom & 32'hFF00_0003);
      upc = ($urandom & 32'h0000_003C) | ($urandom & 32'h0F00_0003);
      step(lp, 1'($urandom), upc, int'($urandom & HMASK), 1'($urandom), "R4");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule